// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a bank of interrupt sources and reduces them to one request line toward a processor. Each source is fixed at elaboration time as edge-captured or level-captured. Captured sources land in a status register. The status is masked by a per-source enable register to form a pending set, and the lowest-numbered pending source is reported as a vector.

Software reaches the block through a single-cycle word bus of eight registers. It can write status directly for testing while hardware capture is off. It acknowledges sources by writing a clear mask. It can set or clear enable bits as one-shot masks, so no read-modify-write is needed. A two-bit master register gates the request output and turns on hardware capture.

Top module: `intc_vectored`

## Requirements
- R1: After synchronous reset, the status, enable and master registers read 0, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: Word indices: 0 status, 1 pending (read-only), 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector (read-only), 7 master. The master register stores only data bits [1:0]: bit 0 is the output enable and bit 1 is the hardware-capture enable. Its upper bits read 0.
- R3: While master bit 1 is 0, a write to word 0 replaces the status register. While master bit 1 is 1, such a write has no effect.
- R4: Pending (word 1) reads status AND enable. Writes to word 1 change nothing.
- R5: Word 2 is written directly. A write to word 4 ORs the data into enable. A write to word 5 clears the enable bits that are set in the data.
- R6: The vector (word 6) reads the index of the lowest-numbered set pending bit, or 0xFFFFFFFF when pending is zero.
- R7: `irq_out` is high exactly when master bit 0 is 1 and pending is nonzero.
- R8: A source whose bit in `EDGE_MASK` is 0 is level type. While master bit 1 is 1 and its input is high, its status bit is set at every clock edge. While master bit 1 is 0, inputs do not change status.
- R9: A source whose bit in `EDGE_MASK` is 1 is edge type. While master bit 1 is 1, a low-to-high change of its input sets its status bit at that clock edge. The bit stays set after the input falls, and an input held high does not set it again.
- R10: A write to word 3 clears the status bits that are set in the data at that edge. A level source still high sets its bit again at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 32 | Interrupt inputs, synchronous to `clk` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A corrupted status or enable bit shows on the pending and vector words in the same cycle it is latched, and on `irq_out` when the output enable is on. Capture faults show one edge after the input stimulus. For a level source, a missed re-set shows one edge after an acknowledge. For an edge source, a spurious re-set shows while the input is held high. A wrong priority order shows as a vector that names a higher-numbered source while a lower one is pending.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC  = 32;
    localparam int DW    = 32;
    localparam int AW    = 3;

    typedef enum logic [AW-1:0] {
        W_STATUS = 3'd0,
        W_PEND   = 3'd1,
        W_ENABLE = 3'd2,
        W_ACK    = 3'd3,
        W_SETEN  = 3'd4,
        W_CLREN  = 3'd5,
        W_VEC    = 3'd6,
        W_MASTER = 3'd7
    } word_e;

    typedef struct packed {
        logic hw_capture;
        logic out_en;
    } master_t;

    function automatic logic [DW-1:0] vec_word(input logic found, input logic [DW-1:0] idx);
        return found ? idx : {DW{1'b1}};
    endfunction

endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int                 N         = 32,
    parameter logic [N-1:0]       EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    output logic [N-1:0] set_vec
);
    logic [N-1:0] src_q;

    always_ff @(posedge clk) src_q <= src;

    generate
        for (genvar g = 0; g < N; g++) begin : g_src
            if (EDGE_MASK[g]) begin : g_edge
                assign set_vec[g] = src[g] & ~src_q[g];
            end else begin : g_level
                assign set_vec[g] = src[g];
            end
        end
    endgenerate

    // R9: an edge-type request needs a low input in the previous cycle
    a_r9_edge_rising: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & EDGE_MASK & $past(src)) == '0));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R6: reported source is pending and nothing below it is
    a_r6_lowest: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> (pend[idx] && ((pend & ((N'(1) << idx) - N'(1))) == '0)));
    a_r6_none: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !found);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    input  logic [N-1:0]    cap_set,
    input  logic [DW-1:0]   vec_rd,
    output logic [DW-1:0]   rdata,
    output logic [N-1:0]    pend,
    output master_t         master
);
    logic [N-1:0] status, enable;
    logic [N-1:0] status_nx, enable_nx;
    master_t      master_nx;
    word_e        w;

    assign w    = word_e'(addr);
    assign pend = status & enable;

    always_comb begin
        status_nx = status;
        enable_nx = enable;
        master_nx = master;
        if (wr) begin
            unique case (w)
                W_STATUS: if (!master.hw_capture) status_nx = wdata[N-1:0];
                W_ENABLE: enable_nx = wdata[N-1:0];
                W_SETEN:  enable_nx = enable | wdata[N-1:0];
                W_CLREN:  enable_nx = enable & ~wdata[N-1:0];
                W_MASTER: master_nx = master_t'(wdata[1:0]);
                default:  ;
            endcase
        end
        if (master.hw_capture) status_nx = status_nx | cap_set;
        if (wr && w == W_ACK)  status_nx = status_nx & ~wdata[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
            master <= '0;
        end else begin
            status <= status_nx;
            enable <= enable_nx;
            master <= master_nx;
        end
    end

    always_comb begin
        unique case (w)
            W_STATUS: rdata = DW'(status);
            W_PEND:   rdata = DW'(pend);
            W_ENABLE: rdata = DW'(enable);
            W_VEC:    rdata = vec_rd;
            W_MASTER: rdata = DW'(master);
            default:  rdata = '0;
        endcase
    end

    // R3: a status write under hardware capture adds nothing beyond captured bits
    a_r3_sw_blocked: assert property (@(posedge clk) disable iff (rst)
        (master.hw_capture && wr && w == W_STATUS) |=>
        ((status & ~$past(status) & ~$past(cap_set)) == '0));
    // R5: clear-enable leaves none of the masked bits set
    a_r5_clr_enable: assert property (@(posedge clk) disable iff (rst)
        (wr && w == W_CLREN) |=> ((enable & $past(wdata[N-1:0])) == '0));
    // R10: acknowledged bits are clear after the edge
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr && w == W_ACK) |=> ((status & $past(wdata[N-1:0])) == '0));
    // R8: with capture on and no acknowledge, captured bits are present next cycle
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        (master.hw_capture && !(wr && w == W_ACK)) |=>
        ((status & $past(cap_set)) == $past(cap_set)));
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
    import intc_pkg::*;
#(
    parameter logic [NSRC-1:0] EDGE_MASK = 32'hFFFF_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] irq_src,
    output logic            irq_out
);
    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0] cap_set, pend;
    logic            found;
    logic [IW-1:0]   idx;
    master_t         master;

    intc_capture #(.N(NSRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk(clk), .rst(rst), .src(irq_src), .set_vec(cap_set));

    intc_prio #(.N(NSRC), .IW(IW)) u_prio (
        .clk(clk), .rst(rst), .pend(pend), .found(found), .idx(idx));

    intc_regs #(.N(NSRC)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .cap_set(cap_set), .vec_rd(vec_word(found, DW'(idx))),
        .rdata(bus_rdata), .pend(pend), .master(master));

    assign irq_out = master.out_en & found;

    // R7: request only when output enabled and something pending
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (master.out_en && pend != '0));
    // R2: master upper bits never read back set
    a_r2_master_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd7) |-> (bus_rdata[DW-1:2] == '0));
endmodule

// File: tb/sim_intc_vectored.sv
module sim_intc_vectored;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_src = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    intc_vectored u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_out(irq_out));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    task automatic t_reset();
        expect_reg("R1 status", 3'd0, 32'h0);
        expect_reg("R1 enable", 3'd2, 32'h0);
        expect_reg("R1 master", 3'd7, 32'h0);
        expect_reg("R1 vector", 3'd6, 32'hFFFF_FFFF);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_master();
        wr(3'd7, 32'hFFFF_FFFF);
        expect_reg("R2 master low bits", 3'd7, 32'h3);
        wr(3'd7, 32'h0);
        expect_reg("R2 master cleared", 3'd7, 32'h0);
    endtask

    task automatic t_software();
        wr(3'd0, 32'h0000_0A00);
        expect_reg("R3 sw status", 3'd0, 32'h0000_0A00);
        wr(3'd2, 32'h0000_0800);
        expect_reg("R4 pending", 3'd1, 32'h0000_0800);
        expect_reg("R6 vector 11", 3'd6, 32'd11);
        check("R7 irq gated off", {31'b0, irq_out}, 32'h0);
        wr(3'd7, 32'h1);
        check("R7 irq on", {31'b0, irq_out}, 32'h1);
        wr(3'd4, 32'h0000_0200);
        expect_reg("R5 set-enable", 3'd2, 32'h0000_0A00);
        expect_reg("R6 vector 9", 3'd6, 32'd9);
        wr(3'd5, 32'h0000_0200);
        expect_reg("R5 clear-enable", 3'd2, 32'h0000_0800);
        wr(3'd1, 32'hFFFF_FFFF);
        expect_reg("R4 pending read-only", 3'd1, 32'h0000_0800);
        wr(3'd3, 32'h0000_0A00);
        expect_reg("R10 ack", 3'd0, 32'h0);
        expect_reg("R6 vector none", 3'd6, 32'hFFFF_FFFF);
        check("R7 irq off when none", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_level();
        irq_src = 32'h0000_0008;
        wr(3'd2, 32'hFFFF_FFFF);
        @(negedge clk);
        expect_reg("R8 no capture when off", 3'd0, 32'h0);
        wr(3'd7, 32'h3);
        @(negedge clk);
        expect_reg("R8 level captured", 3'd0, 32'h0000_0008);
        check("R7 irq level", {31'b0, irq_out}, 32'h1);
        wr(3'd0, 32'h0000_00F0);
        expect_reg("R3 sw write ignored", 3'd0, 32'h0000_0008);
        wr(3'd3, 32'h0000_0008);
        expect_reg("R10 ack clears", 3'd0, 32'h0);
        @(negedge clk);
        expect_reg("R10 level re-sets", 3'd0, 32'h0000_0008);
        irq_src = 32'h0;
        wr(3'd3, 32'h0000_0008);
        @(negedge clk);
        expect_reg("R10 stays clear", 3'd0, 32'h0);
    endtask

    task automatic t_edge();
        @(negedge clk);
        irq_src = 32'h0010_0000;
        @(negedge clk);
        irq_src = 32'h0;
        @(negedge clk);
        expect_reg("R9 edge held", 3'd0, 32'h0010_0000);
        expect_reg("R6 vector 20", 3'd6, 32'd20);
        wr(3'd3, 32'h0010_0000);
        expect_reg("R9 edge acked", 3'd0, 32'h0);
        irq_src = 32'h0020_0000;
        @(negedge clk);
        expect_reg("R9 edge 21", 3'd0, 32'h0020_0000);
        wr(3'd3, 32'h0020_0000);
        @(negedge clk);
        @(negedge clk);
        expect_reg("R9 held high no re-set", 3'd0, 32'h0);
        irq_src = 32'h8020_0000;
        @(negedge clk);
        expect_reg("R6 vector 31", 3'd6, 32'd31);
        irq_src = 32'h0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_master();
        t_software();
        t_level();
        t_edge();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule